// File: doc/BRIEF.md
# Overlay Window Scanout Address Generator

This block produces the memory read requests that fetch one overlay window's pixels from its framebuffer while the display is scanning. Software supplies a window description: a byte base address, the line stride in pixels (visible width plus any padding), the visible width and height, a source offset (X, Y) into the buffer, and a pixel format code. A display timing source pulses `line_start` once per line. For each pulse the block computes where the next visible line begins in memory and issues a run of word-granular burst read requests over a valid/ready handshake until the whole visible span of that line has been requested.

Each burst is at most 16 words long. A narrow buffer, whose padded stride is below 128 pixels, uses 8-word bursts instead, because long bursts on very small buffers such as cursors are known to cause tearing. The last burst of a line is trimmed so that no read extends past the visible span. When the final burst of the last visible line is accepted, the block raises a one-cycle end-of-frame pulse and restarts its line count. The window description is sampled at the first line of every frame, so software may rewrite it at any time without disturbing a frame in progress.

The visible width and height must be at least 1, and `src_x + vis_w` is expected not to exceed the stride.

Top module: `wsa_window_fetch`

## Requirements
- R1: After reset, `req_valid` and `frame_end` are 0 and the line count is 0, so the first `line_start` fetches line 0.
- R2: For visible line n the first request address is A rounded down to a multiple of 4, where A = base + ((src_y + n) * stride + src_x) * P and P is the pixel size in bytes, all modulo 2^32.
- R3: The bursts of one line together request exactly ceil((A mod 4 + vis_w * P) / 4) words; every burst but the last of a line has the full burst length and the last carries the remainder.
- R4: The burst length is 16 words when the stride is 128 pixels or more and 8 words when the stride is below 128 pixels.
- R5: Format code 0 selects 2-byte pixels; codes 1, 2 and 3 select 4-byte pixels (code 3 being the fallback for an unrecognised format).
- R6: While `req_valid` is high and `req_ready` low, `req_addr` and `req_beats` hold their values; after an accepted burst the next burst of the same line starts at the previous address plus 4 times its beat count.
- R7: `frame_end` is high for exactly one cycle, the cycle after the final burst of line vis_h - 1 is accepted, and is low at all other times; the next `line_start` then fetches line 0 again.
- R8: A `line_start` pulse that arrives while a line is still being requested is ignored: the burst sequence and the line count are unchanged.
- R9: The window description is captured at the `line_start` of line 0; changing the configuration inputs during lines 1 to vis_h - 1 has no effect on that frame.
- R10: Once the last burst of a line is accepted, `req_valid` stays low until the next `line_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 32 | Buffer base byte address |
| cfg_stride_px | input | 13 | Line stride in pixels (width plus padding) |
| cfg_vis_w | input | 13 | Visible width in pixels |
| cfg_vis_h | input | 12 | Visible height in lines |
| cfg_src_x | input | 13 | Source X offset in pixels |
| cfg_src_y | input | 12 | Source Y offset in lines |
| cfg_fmt | input | 2 | Pixel format code (0: 2 bytes, 1 to 3: 4 bytes) |
| line_start | input | 1 | One-cycle pulse that starts fetching the next line |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | 32 | Word-aligned byte address of the burst |
| req_beats | output | 5 | Burst length in 32-bit words |
| frame_end | output | 1 | One-cycle pulse after the last burst of the frame |

## Verification
A `line_start` sampled at one rising edge puts the first burst of that line on `req_addr` and `req_beats` right after that edge, with no further pipeline stage, and each accepted burst presents its successor right after the accepting edge. `frame_end` rises one edge after the last accepting edge and falls at the next. The bench drives and samples only on the falling edge, compares the request against the arithmetic model in every cycle that `req_valid` is high, and checks `frame_end` and the idle request at the first falling edge after each line's final acceptance, sweeping formats, strides on both sides of 128, aligned and misaligned bases, and offsets.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

    localparam int ADDR_W = 32;
    localparam int PIX_W  = 13;
    localparam int LINE_W = 12;
    localparam int BEAT_W = 5;
    localparam int WCNT_W = PIX_W + 3;

    typedef enum logic [1:0] {
        FMT_RGB16  = 2'd0,
        FMT_XRGB32 = 2'd1,
        FMT_ARGB32 = 2'd2,
        FMT_OTHER  = 2'd3
    } pix_fmt_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [PIX_W-1:0]  stride_px;
        logic [PIX_W-1:0]  vis_w;
        logic [LINE_W-1:0] vis_h;
        logic [PIX_W-1:0]  src_x;
        logic [LINE_W-1:0] src_y;
        pix_fmt_e          fmt;
    } win_cfg_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_REQ  = 1'b1
    } seq_state_e;

    // Bytes per pixel; anything that is not the 16-bit format is fetched as 4 bytes.
    function automatic logic [2:0] bytes_per_px(input pix_fmt_e f);
        return (f == FMT_RGB16) ? 3'd2 : 3'd4;
    endfunction

endpackage

// File: rtl/wsa_line_calc.sv
module wsa_line_calc
    import wsa_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [PIX_W-1:0]  stride_px,
    input  logic [PIX_W-1:0]  vis_w,
    input  logic [PIX_W-1:0]  src_x,
    input  logic [LINE_W-1:0] src_y,
    input  pix_fmt_e          fmt,
    input  logic [LINE_W-1:0] line_idx,
    output logic [ADDR_W-1:0] line_addr,
    output logic [WCNT_W-1:0] line_words
);
    logic [ADDR_W-1:0] row;
    logic [ADDR_W-1:0] pix;
    logic [ADDR_W-1:0] raw;
    logic [2:0]        bpp;
    logic [WCNT_W-1:0] span;

    always_comb begin
        bpp        = bytes_per_px(fmt);
        row        = ADDR_W'(src_y) + ADDR_W'(line_idx);
        pix        = row * ADDR_W'(stride_px) + ADDR_W'(src_x);
        raw        = base + pix * ADDR_W'(bpp);
        line_addr  = {raw[ADDR_W-1:2], 2'b00};
        span       = WCNT_W'(raw[1:0]) + WCNT_W'(vis_w) * WCNT_W'(bpp) + WCNT_W'(3);
        line_words = span >> 2;
    end
endmodule

// File: rtl/wsa_burst_seq.sv
module wsa_burst_seq
    import wsa_pkg::*;
#(
    parameter int BURST_LONG   = 16,
    parameter int BURST_SHORT  = 8,
    parameter int NARROW_LIMIT = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic [WCNT_W-1:0] line_words,
    input  logic [PIX_W-1:0]  stride_px,
    input  logic [LINE_W-1:0] vis_h,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BEAT_W-1:0] req_beats,
    output logic              frame_end,
    output logic              seq_idle,
    output logic [LINE_W-1:0] line_idx
);
    localparam logic [BEAT_W-1:0] CAP_LONG  = BEAT_W'(BURST_LONG);
    localparam logic [BEAT_W-1:0] CAP_SHORT = BEAT_W'(BURST_SHORT);
    localparam logic [PIX_W-1:0]  NARROW_PX = PIX_W'(NARROW_LIMIT);

    seq_state_e        state;
    logic [ADDR_W-1:0] cur_addr;
    logic [WCNT_W-1:0] words_left;
    logic [BEAT_W-1:0] cap;
    logic              line_done;

    always_comb begin
        cap       = (stride_px < NARROW_PX) ? CAP_SHORT : CAP_LONG;
        req_beats = (words_left < WCNT_W'(cap)) ? BEAT_W'(words_left) : cap;
        req_valid = (state == SEQ_REQ);
        req_addr  = cur_addr;
        seq_idle  = (state == SEQ_IDLE);
        line_done = (words_left == WCNT_W'(req_beats));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            cur_addr   <= '0;
            words_left <= '0;
            line_idx   <= '0;
            frame_end  <= 1'b0;
        end else begin
            frame_end <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (line_start) begin
                        cur_addr   <= line_addr;
                        words_left <= line_words;
                        state      <= SEQ_REQ;
                    end
                end
                SEQ_REQ: begin
                    if (req_ready) begin
                        cur_addr   <= cur_addr + (ADDR_W'(req_beats) << 2);
                        words_left <= words_left - WCNT_W'(req_beats);
                        if (line_done) begin
                            state <= SEQ_IDLE;
                            if (line_idx == vis_h - LINE_W'(1)) begin
                                line_idx  <= '0;
                                frame_end <= 1'b1;
                            end else begin
                                line_idx <= line_idx + LINE_W'(1);
                            end
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wsa_window_fetch.sv
module wsa_window_fetch
    import wsa_pkg::*;
#(
    parameter int BURST_LONG   = 16,
    parameter int BURST_SHORT  = 8,
    parameter int NARROW_LIMIT = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [PIX_W-1:0]  cfg_stride_px,
    input  logic [PIX_W-1:0]  cfg_vis_w,
    input  logic [LINE_W-1:0] cfg_vis_h,
    input  logic [PIX_W-1:0]  cfg_src_x,
    input  logic [LINE_W-1:0] cfg_src_y,
    input  logic [1:0]        cfg_fmt,
    input  logic              line_start,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BEAT_W-1:0] req_beats,
    output logic              frame_end
);
    win_cfg_t          live_cfg;
    win_cfg_t          held_cfg;
    win_cfg_t          eff_cfg;
    logic              seq_idle;
    logic [LINE_W-1:0] line_idx;
    logic              take_live;
    logic [ADDR_W-1:0] line_addr;
    logic [WCNT_W-1:0] line_words;

    always_comb begin
        live_cfg.base      = cfg_base;
        live_cfg.stride_px = cfg_stride_px;
        live_cfg.vis_w     = cfg_vis_w;
        live_cfg.vis_h     = cfg_vis_h;
        live_cfg.src_x     = cfg_src_x;
        live_cfg.src_y     = cfg_src_y;
        live_cfg.fmt       = pix_fmt_e'(cfg_fmt);
        take_live          = seq_idle && (line_idx == '0);
        eff_cfg            = take_live ? live_cfg : held_cfg;
    end

    // Frame-level shadow: loaded on the first line of each frame only.
    always_ff @(posedge clk) begin
        if (rst) begin
            held_cfg <= '0;
        end else if (take_live && line_start) begin
            held_cfg <= live_cfg;
        end
    end

    wsa_line_calc i_calc (
        .base       (eff_cfg.base),
        .stride_px  (eff_cfg.stride_px),
        .vis_w      (eff_cfg.vis_w),
        .src_x      (eff_cfg.src_x),
        .src_y      (eff_cfg.src_y),
        .fmt        (eff_cfg.fmt),
        .line_idx   (line_idx),
        .line_addr  (line_addr),
        .line_words (line_words)
    );

    wsa_burst_seq #(
        .BURST_LONG   (BURST_LONG),
        .BURST_SHORT  (BURST_SHORT),
        .NARROW_LIMIT (NARROW_LIMIT)
    ) i_seq (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .line_addr  (line_addr),
        .line_words (line_words),
        .stride_px  (eff_cfg.stride_px),
        .vis_h      (eff_cfg.vis_h),
        .req_ready  (req_ready),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_beats  (req_beats),
        .frame_end  (frame_end),
        .seq_idle   (seq_idle),
        .line_idx   (line_idx)
    );
endmodule

// File: rtl/wsa_window_fetch_chk.sv
module wsa_window_fetch_chk
    import wsa_pkg::*;
#(
    parameter int BURST_LONG   = 16,
    parameter int BURST_SHORT  = 8,
    parameter int NARROW_LIMIT = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [BEAT_W-1:0] req_beats,
    input logic              frame_end,
    input logic [PIX_W-1:0]  eff_stride
);
    // R6: a stalled request keeps address and length
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_beats)));

    // R2: every request address is word aligned
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr[1:0] == 2'b00));

    // R3: no empty burst and none longer than the long burst
    a_r3_beats_range: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_beats != '0 && int'(req_beats) <= BURST_LONG));

    // R4: a narrow stride never gets a long burst
    a_r4_narrow_cap: assert property (@(posedge clk) disable iff (rst)
        (req_valid && int'(eff_stride) < NARROW_LIMIT) |-> (int'(req_beats) <= BURST_SHORT));

    // R7: end-of-frame lasts one cycle and only follows an accepted burst
    a_r7_pulse_once: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end);

    a_r7_after_accept: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> $past(req_valid && req_ready));

    // R10: after the end of a frame no request is pending
    a_r10_idle_after_frame: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> !req_valid);
endmodule

bind wsa_window_fetch wsa_window_fetch_chk #(
    .BURST_LONG   (BURST_LONG),
    .BURST_SHORT  (BURST_SHORT),
    .NARROW_LIMIT (NARROW_LIMIT)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_beats  (req_beats),
    .frame_end  (frame_end),
    .eff_stride (eff_cfg.stride_px)
);

// File: tb/test_wsa_window_fetch.sv
module test_wsa_window_fetch;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_base = '0;
    logic [12:0] cfg_stride_px = '0;
    logic [12:0] cfg_vis_w = '0;
    logic [11:0] cfg_vis_h = '0;
    logic [12:0] cfg_src_x = '0;
    logic [11:0] cfg_src_y = '0;
    logic [1:0]  cfg_fmt = '0;
    logic        line_start = 1'b0;
    logic        req_ready = 1'b0;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [4:0]  req_beats;
    logic        frame_end;

    int n_chk = 0;
    int n_bad = 0;
    int rdy_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wsa_window_fetch i_wsa_window_fetch (
        .clk           (clk),
        .rst           (rst),
        .cfg_base      (cfg_base),
        .cfg_stride_px (cfg_stride_px),
        .cfg_vis_w     (cfg_vis_w),
        .cfg_vis_h     (cfg_vis_h),
        .cfg_src_x     (cfg_src_x),
        .cfg_src_y     (cfg_src_y),
        .cfg_fmt       (cfg_fmt),
        .line_start    (line_start),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_beats     (req_beats),
        .frame_end     (frame_end)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // One frame; cfg values are the model. change_cfg scribbles on the inputs after line 0 (R9),
    // poke raises line_start while a request is stalled (R8).
    task automatic run_frame(input longint base, input int stride, input int vw, input int vh,
                             input int sx, input int sy, input int fmt,
                             input bit change_cfg, input bit poke);
        int bpp;
        int cap;
        bit poked;
        bpp = (fmt == 0) ? 2 : 4;
        cap = (stride < 128) ? 8 : 16;
        cfg_base = base[31:0]; cfg_stride_px = 13'(stride); cfg_vis_w = 13'(vw);
        cfg_vis_h = 12'(vh); cfg_src_x = 13'(sx); cfg_src_y = 12'(sy); cfg_fmt = 2'(fmt);
        poked = 1'b0;
        for (int n = 0; n < vh; n++) begin
            longint raw;
            longint exp_addr;
            int words_left;
            int exp_beats;
            raw = (base + longint'((sy + n) * stride + sx) * bpp) & 64'hFFFF_FFFF;
            exp_addr = raw & ~longint'(3);
            words_left = int'(((raw & 3) + vw * bpp + 3) / 4);
            line_start = 1'b1;
            @(posedge clk); #1;
            @(negedge clk);
            line_start = 1'b0;
            if (change_cfg && n == 0) begin
                cfg_base = 32'hDEAD_0000; cfg_stride_px = 13'd7; cfg_fmt = 2'd0;
                cfg_vis_w = 13'd1; cfg_vis_h = 12'd40; cfg_src_x = 13'd0; cfg_src_y = 12'd0;
            end
            while (words_left > 0) begin
                req_ready = (rdy_cnt % 3) != 0;
                rdy_cnt++;
                exp_beats = (words_left < cap) ? words_left : cap;
                // R2 address, R3/R4/R5 length, R6 stability, R9 shadowing
                chk(req_valid == 1'b1, "R3 req_valid during line", req_valid, 1);
                chk(longint'(req_addr) == exp_addr, "R2/R6/R9 req_addr", req_addr, exp_addr);
                chk(int'(req_beats) == exp_beats, "R3/R4/R5 req_beats", req_beats, exp_beats);
                if (poke && !poked && !req_ready) begin
                    line_start = 1'b1;   // R8: must be ignored
                    poked = 1'b1;
                end
                if (req_ready) begin
                    exp_addr += 4 * exp_beats;
                    words_left -= exp_beats;
                end
                @(posedge clk); #1;
                @(negedge clk);
                line_start = 1'b0;
                req_ready = 1'b0;
            end
            // R7 / R10: first falling edge after final acceptance
            chk(frame_end == (n == vh - 1), "R7 frame_end after line", frame_end, (n == vh - 1));
            chk(req_valid == 1'b0, "R10 idle after line", req_valid, 0);
            @(negedge clk);
            chk(frame_end == 1'b0, "R7 frame_end single cycle", frame_end, 0);
            chk(req_valid == 1'b0, "R10 still idle", req_valid, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(req_valid == 1'b0, "R1 req_valid after reset", req_valid, 0);
        chk(frame_end == 1'b0, "R1 frame_end after reset", frame_end, 0);
        @(negedge clk);
        chk(req_valid == 1'b0, "R10 no request without line_start", req_valid, 0);

        // R1: first line after reset is line 0 (src_y offset alone)
        run_frame(64'h0000_4000, 40, 30, 2, 2, 1, 1, 1'b0, 1'b0);

        // Sweep: format (R5), stride around 128 (R4), offsets and misaligned base (R2/R3)
        for (int fi = 0; fi < 4; fi++) begin
            for (int si = 0; si < 5; si++) begin
                for (int oi = 0; oi < 2; oi++) begin
                    for (int bi = 0; bi < 2; bi++) begin
                        int strides[5] = '{20, 64, 127, 128, 200};
                        int st;
                        int ox;
                        int oy;
                        int vw;
                        longint b;
                        st = strides[si];
                        ox = oi * 3;
                        oy = oi * 5;
                        vw = st - ox - fi;
                        b  = (bi == 0) ? 64'h1000_0000 : 64'h2000_0006;
                        run_frame(b, st, vw, 2 + (fi % 2), ox, oy, fi,
                                  1'b0, (si + oi) % 2 == 1);
                    end
                end
            end
        end

        // R9: configuration rewritten during the frame must not matter
        run_frame(64'h3000_0002, 150, 141, 3, 5, 2, 0, 1'b1, 1'b0);
        // next frame takes fresh configuration from line 0 (R7 wrap, R9)
        run_frame(64'h0800_0000, 96, 90, 2, 1, 3, 2, 1'b0, 1'b1);

        finish_run();
    end
endmodule